// File: doc/BRIEF.md
# DMA Peripheral Request Source Selector

This block sits beside each channel of a DMA controller and turns a 4-bit request-select code into one gated transfer request. The code picks one of the on-chip peripheral request lines: the transmit-empty or receive-full line of one of two serial ports, or a timer input-capture event. The code also fixes which side of the transfer is external memory and which side is a peripheral register, so the address logic can read both kinds from this block. The block checks the channel's bus mode against the modes that the selection allows.

When the address logic reports a completed transfer, the block raises a one-cycle clear pulse back to the peripheral whose request was served. In cycle-steal mode it does this on every transfer. In burst mode it does this only on the final transfer. A timer capture event is held as one pending flag that all channels share. Among the enabled channels that select the timer, the lowest-numbered one wins the event, and its clear also clears the flag for the channels that lost.

Top module: `dma_periph_req_sel`

## Requirements
- R1: Codes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 select serial line k = code[1:0]: bit 0 is port A transmit-empty, bit 1 is port A receive-full, bit 2 is port B transmit-empty and bit 3 is port B receive-full. With no other condition blocking it, req[i] follows ser_req[k] in the same cycle.
- R2: Address kinds use the encoding 2'b01 for external and 2'b10 for an on-chip peripheral register. Transmit codes (code[0]=0) give src 01 and dst 10. Receive codes (code[0]=1) give src 10 and dst 01.
- R3: A serial code with ch_burst[i]=1 sets illegal[i]=1 and holds req[i]=0.
- R4: Codes 4'b1100, 4'b1101 and 4'b1110 select the timer capture and give src/dst kinds 01/01, 01/10 and 10/01. Burst and cycle-steal are both legal with these codes, so illegal[i]=0.
- R5: req[i] is 0 when ch_en[i]=0. A serial request also needs ser_dma_en[k]=1.
- R6: Any other code gives req=0, kinds 00/00 and illegal=0.
- R7: A cap_evt pulse sampled at a clock edge, with cap_en not 2'b00, makes the capture pending from that edge onward. Only the lowest-numbered enabled channel that selects the timer asserts req.
- R8: In cycle-steal mode (ch_burst=0), xfer_done[i] while req[i]=1 pulses the matching clear output in the same cycle: ser_clr[k] for a serial code, cap_clr for a timer code.
- R9: In burst mode, the clear is pulsed only when xfer_done[i] and xfer_last[i] are both 1. Until then the request is kept.
- R10: cap_en=2'b00 blocks every capture request at once and discards a pending capture at the next edge.
- R11: After cap_clr, the pending capture is gone for every channel. A cap_evt in the same cycle as cap_clr leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| ch_en | input | NCH | channel enable |
| ch_burst | input | NCH | 1 = burst mode, 0 = cycle-steal |
| ch_sel | input | NCH*SW | request-select code per channel |
| xfer_done | input | NCH | a transfer completed on the channel |
| xfer_last | input | NCH | the completing transfer is the last of the block |
| ser_req | input | 4 | serial request lines |
| ser_dma_en | input | 4 | DMA-request enable of each serial line |
| cap_evt | input | 1 | timer capture event pulse |
| cap_en | input | 2 | timer capture request enables |
| req | output | NCH | gated transfer request |
| illegal | output | NCH | mode/source combination is not allowed |
| src_kind | output | NCH*KW | source kind per channel |
| dst_kind | output | NCH*KW | destination kind per channel |
| ser_clr | output | 4 | clear pulse to each serial line |
| cap_clr | output | 1 | clear pulse to the timer capture |

## Verification
Each serial code is driven with its own line raised and with that line low, to confirm that the index decode selects the right line and not a neighbour. The same codes are repeated with the channel enable off, the peripheral enable off and burst mode on, which separates the three gates from one another. Capture events are applied with two competing channels, in both bus modes and with non-final and final completions, to show who wins and when the shared flag drains. A further case has an event that coincides with a clear, and another turns the enables off while a capture is pending.

// File: rtl/dma_periph_req_sel.sv
module dma_periph_req_sel #(
  parameter int NCH = 4,
  parameter int SW  = 4,
  parameter int KW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    ch_burst,
  input  logic [NCH*SW-1:0] ch_sel,
  input  logic [NCH-1:0]    xfer_done,
  input  logic [NCH-1:0]    xfer_last,
  input  logic [3:0]        ser_req,
  input  logic [3:0]        ser_dma_en,
  input  logic              cap_evt,
  input  logic [1:0]        cap_en,
  output logic [NCH-1:0]    req,
  output logic [NCH-1:0]    illegal,
  output logic [NCH*KW-1:0] src_kind,
  output logic [NCH*KW-1:0] dst_kind,
  output logic [3:0]        ser_clr,
  output logic              cap_clr
);
  localparam logic [KW-1:0] K_NONE = KW'(0);
  localparam logic [KW-1:0] K_EXT  = KW'(1);
  localparam logic [KW-1:0] K_REG  = KW'(2);

  logic cap_pend;
  wire  cap_live = cap_pend & (|cap_en);

  always_comb begin
    logic [SW-1:0] code;
    logic is_ser, is_cap, taken, clr_i;
    req      = '0;
    illegal  = '0;
    src_kind = '0;
    dst_kind = '0;
    ser_clr  = '0;
    cap_clr  = 1'b0;
    taken    = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      code   = ch_sel[i*SW +: SW];
      is_ser = (code[3:2] == 2'b10) && (code[SW-1:4] == '0 || SW == 4);
      is_cap = (code[3:2] == 2'b11) && (code[1:0] != 2'b11) && (code[SW-1:4] == '0 || SW == 4);
      if (is_ser) begin
        src_kind[i*KW +: KW] = code[0] ? K_REG : K_EXT;
        dst_kind[i*KW +: KW] = code[0] ? K_EXT : K_REG;
        illegal[i] = ch_burst[i];
        req[i] = ch_en[i] & ~ch_burst[i] & ser_dma_en[code[1:0]] & ser_req[code[1:0]];
      end else if (is_cap) begin
        src_kind[i*KW +: KW] = (code[1:0] == 2'b10) ? K_REG : K_EXT;
        dst_kind[i*KW +: KW] = (code[1:0] == 2'b01) ? K_REG : K_EXT;
        req[i] = ch_en[i] & ~taken & cap_live;
        taken  = taken | ch_en[i];
      end else begin
        src_kind[i*KW +: KW] = K_NONE;
        dst_kind[i*KW +: KW] = K_NONE;
      end
      clr_i = xfer_done[i] & req[i] & (~ch_burst[i] | xfer_last[i]);
      if (is_ser && clr_i) ser_clr[code[1:0]] = 1'b1;
      if (is_cap && clr_i) cap_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cap_pend <= 1'b0;
    else if (cap_en == 2'b00) cap_pend <= 1'b0;
    else if (cap_evt)         cap_pend <= 1'b1;
    else if (cap_clr)         cap_pend <= 1'b0;
  end
endmodule

module dma_periph_req_sel_chk #(
  parameter int NCH = 4,
  parameter int SW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_burst,
  input logic [NCH*SW-1:0] ch_sel,
  input logic [NCH-1:0]    xfer_done,
  input logic [NCH-1:0]    xfer_last,
  input logic              cap_evt,
  input logic [1:0]        cap_en,
  input logic [NCH-1:0]    req,
  input logic [NCH-1:0]    illegal,
  input logic              cap_clr
);
  logic [NCH-1:0] capmask;
  always_comb
    for (int i = 0; i < NCH; i++)
      capmask[i] = (ch_sel[i*SW +: 4] inside {4'b1100, 4'b1101, 4'b1110});

  // R3
  illegal_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(illegal & req)));
  // R5
  disabled_chan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req & ~ch_en)));
  // R7
  single_cap_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req & capmask));
  // R10
  cap_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en == 2'b00) |-> !(|(req & capmask)));
  // R11
  cap_clr_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_clr && !cap_evt) |=> !(|(req & capmask)));
  // R9
  cap_clr_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_clr |-> |(xfer_done & (~ch_burst | xfer_last)));
endmodule

bind dma_periph_req_sel dma_periph_req_sel_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_burst(ch_burst), .ch_sel(ch_sel),
  .xfer_done(xfer_done), .xfer_last(xfer_last), .cap_evt(cap_evt), .cap_en(cap_en),
  .req(req), .illegal(illegal), .cap_clr(cap_clr)
);

// File: tb/dma_periph_req_sel_bench.sv
module dma_periph_req_sel_bench;
  localparam int NCH = 4, SW = 4, KW = 2;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ch_en, ch_burst, xfer_done, xfer_last, req, illegal;
  logic [NCH*SW-1:0] ch_sel;
  logic [3:0] ser_req, ser_dma_en, ser_clr;
  logic cap_evt, cap_clr;
  logic [1:0] cap_en;
  logic [NCH*KW-1:0] src_kind, dst_kind;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dma_periph_req_sel #(.NCH(NCH), .SW(SW), .KW(KW)) u_dma_periph_req_sel (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ch_en = '0; ch_burst = '0; ch_sel = '0; xfer_done = '0; xfer_last = '0;
    ser_req = '0; ser_dma_en = '0; cap_evt = 0; cap_en = 2'b00;
  endtask

  task automatic setch(int i, logic [3:0] code, logic en, logic burst);
    ch_sel[i*SW +: SW] = code; ch_en[i] = en; ch_burst[i] = burst;
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic t_reset();
    check("R7 reset req", req, 0);
    check("R6 reset kinds", {src_kind, dst_kind}, 0);
  endtask

  task automatic t_serial();
    idle(); @(negedge clk);
    ser_dma_en = 4'hF;
    setch(0, 4'b1000, 1, 0); ser_req = 4'b0001; #1;
    check("R1 port A tx req", req, 4'b0001);
    check("R2 tx src", src_kind[1:0], 2'b01);
    check("R2 tx dst", dst_kind[1:0], 2'b10);
    setch(0, 4'b1001, 1, 0); #1;
    check("R1 wrong line low", req, 0);
    ser_req = 4'b0010; #1;
    check("R1 port A rx req", req, 4'b0001);
    check("R2 rx kinds", {src_kind[1:0], dst_kind[1:0]}, 4'b1001);
    setch(2, 4'b1011, 1, 0); ser_req = 4'b1000; #1;
    check("R1 port B rx on ch2", req, 4'b0100);
    setch(2, 4'b1010, 1, 0); ser_req = 4'b0100; #1;
    check("R1 port B tx on ch2", req, 4'b0100);
  endtask

  task automatic t_gates();
    idle(); @(negedge clk);
    ser_dma_en = 4'hF; ser_req = 4'hF;
    setch(1, 4'b1000, 0, 0); #1;
    check("R5 channel off", req, 0);
    ch_en[1] = 1; ser_dma_en = 4'b1110; #1;
    check("R5 dma enable off", req, 0);
    ser_dma_en = 4'hF; #1;
    check("R5 both on", req, 4'b0010);
  endtask

  task automatic t_illegal();
    idle(); @(negedge clk);
    ser_dma_en = 4'hF; ser_req = 4'hF;
    setch(3, 4'b1010, 1, 1); #1;
    check("R3 illegal flag", illegal, 4'b1000);
    check("R3 no req", req, 0);
  endtask

  task automatic t_unlisted();
    idle(); @(negedge clk);
    ser_dma_en = 4'hF; ser_req = 4'hF; cap_en = 2'b01;
    setch(0, 4'b1111, 1, 1); setch(1, 4'b0011, 1, 0); cap_evt = 1;
    step(); cap_evt = 0; #1;
    check("R6 unlisted req", req, 0);
    check("R6 unlisted kinds", {src_kind[3:0], dst_kind[3:0]}, 0);
    check("R6 unlisted illegal", illegal, 0);
  endtask

  task automatic t_cap_kinds();
    idle(); @(negedge clk);
    setch(0, 4'b1100, 1, 1); setch(1, 4'b1101, 1, 0); setch(2, 4'b1110, 1, 1); #1;
    check("R4 C kinds", {src_kind[1:0], dst_kind[1:0]}, 4'b0101);
    check("R4 D kinds", {src_kind[3:2], dst_kind[3:2]}, 4'b0110);
    check("R4 E kinds", {src_kind[5:4], dst_kind[5:4]}, 4'b1001);
    check("R4 burst legal", illegal, 0);
  endtask

  task automatic t_priority_cs();
    idle(); @(negedge clk);
    cap_en = 2'b01;
    setch(1, 4'b1100, 1, 0); setch(3, 4'b1101, 1, 0); setch(0, 4'b1100, 0, 0); #1;
    check("R7 no event no req", req, 0);
    cap_evt = 1; step(); cap_evt = 0; #1;
    check("R7 lowest enabled wins", req, 4'b0010);
    xfer_done[1] = 1; #1;
    check("R8 cycle-steal clear", cap_clr, 1);
    step(); xfer_done = '0; #1;
    check("R11 loser not served", req, 0);
  endtask

  task automatic t_burst();
    idle(); @(negedge clk);
    cap_en = 2'b10;
    setch(1, 4'b1110, 1, 1); setch(2, 4'b1100, 1, 1);
    cap_evt = 1; step(); cap_evt = 0;
    xfer_done[1] = 1; #1;
    check("R9 non-last no clear", cap_clr, 0);
    step(); xfer_done = '0; #1;
    check("R9 burst keeps req", req, 4'b0010);
    xfer_done[1] = 1; xfer_last[1] = 1; #1;
    check("R9 last clears", cap_clr, 1);
    step(); xfer_done = '0; xfer_last = '0; #1;
    check("R9 req gone", req, 0);
  endtask

  task automatic t_ser_clear();
    idle(); @(negedge clk);
    ser_dma_en = 4'hF; ser_req = 4'b0010;
    setch(2, 4'b1001, 1, 0); xfer_done[2] = 1; #1;
    check("R8 serial clear pulse", ser_clr, 4'b0010);
    xfer_done = '0; #1;
    check("R8 no clear without done", ser_clr, 0);
  endtask

  task automatic t_cap_off();
    idle(); @(negedge clk);
    cap_en = 2'b01; setch(0, 4'b1100, 1, 0);
    cap_evt = 1; step(); cap_evt = 0; #1;
    check("R7 pending ch0", req, 4'b0001);
    cap_en = 2'b00; #1;
    check("R10 immediate block", req, 0);
    step(); cap_en = 2'b01; #1;
    check("R10 pending discarded", req, 0);
    cap_en = 2'b00; cap_evt = 1; step(); cap_evt = 0; cap_en = 2'b01; #1;
    check("R10 event ignored", req, 0);
  endtask

  task automatic t_coincide();
    idle(); @(negedge clk);
    cap_en = 2'b11; setch(0, 4'b1101, 1, 0);
    cap_evt = 1; step();
    xfer_done[0] = 1; #1;
    check("R11 clear with event", cap_clr, 1);
    step(); cap_evt = 0; xfer_done = '0; #1;
    check("R11 new event kept", req, 4'b0001);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    #1; t_reset();
    rst_n = 1;
    t_serial(); t_gates(); t_illegal(); t_unlisted(); t_cap_kinds();
    t_priority_cs(); t_burst(); t_ser_clear(); t_cap_off(); t_coincide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule